// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible register file of a single DMA channel. It holds the descriptor pointer, the buffer start address, the channel configuration, the two-dimensional count and stride settings, the live progress registers and the status bits. A host reaches it through a simple register port that reads and writes either a full 32-bit word or one 16-bit half of a slot. The channel sequencer, which moves the data, reads the settings straight from the bank's outputs. It gets start and stop pulses, and it writes progress and completion back through a dedicated update port.

Every slot lies on a 4-byte stride. The register port carries the halfword address: bits [4:1] pick the slot and bit [0] picks the upper half for 16-bit accesses. While the channel runs, the bank protects the transfer set-up from host writes. Only the configuration word and the status word stay writable. Writing the configuration word is the one way the host starts or stops the channel.

Top module: `dma_chan_regs`

## Requirements
- R1: Slots are decoded by halfword address bits [4:1]. The slot indices are: 0 next descriptor pointer, 1 start address, 2 configuration, 4 X count, 5 X stride, 6 Y count, 7 Y stride, 8 current descriptor pointer, 9 current address, 10 status, 11 peripheral map, 12 current X count, 14 current Y count. Slots 3, 13 and 15 are reserved.
- R2: The four pointer/address slots (0, 1, 8, 9) are 32 bits wide. A 16-bit write updates only the half chosen by bit [0], with the data taken from busWData[15:0]. The other slots are 16 bits wide. They take data from a 32-bit write or from a lower-half 16-bit write, and an upper-half 16-bit write has no effect on them.
- R3: While the run bit is set, writes to every slot other than configuration (2) and status (10) are discarded.
- R4: A peripheral map write keeps the stored bit CTYPE_BIT (default 6, peripheral-type channel when 1) and takes all other bits from the write data.
- R5: In the status word, done is bit 0, error is bit 1 and run is bit 3. Writing 1 to done or error clears that bit, and writing 0 leaves it unchanged. Run cannot be written through status. When a sequencer set and a host clear of the same bit fall in the same cycle, the set wins.
- R6: Writing the configuration word copies its 16 bits. If enable (bit 0) is 1, run is set. If enable is 0, run is cleared and stopPulse is high for one cycle.
- R7: A configuration write with enable set raises startPulse for one cycle only when the channel is memory-type (CTYPE clear) or direction (bit 1) is 1, meaning the channel writes memory. Otherwise run is set with no pulse.
- R8: Any slot can be read as 32 bits or as either 16-bit half, with the half returned on busRData[15:0] and the upper bits zero. Reserved slots and the unused half of 16-bit slots read as zero.
- R9: After reset every register is zero except the peripheral map, which holds PMAP_RESET.
- R10: A write to a reserved slot changes nothing and raises badAccess for exactly the following cycle.
- R11: seqLoad loads the current descriptor pointer, current address, current X count and current Y count from the sequencer, overriding a host write in the same cycle. seqHalt clears run unless a configuration write happens in the same cycle, in which case the write decides run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busSel | input | 1 | Register access valid |
| busWr | input | 1 | 1 = write, 0 = read |
| busHalfAddr | input | 5 | Halfword address: [4:1] slot, [0] upper half |
| busSize32 | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, combinational |
| seqLoad | input | 1 | Load current-state registers |
| seqDesc | input | 32 | New current descriptor pointer |
| seqAddr | input | 32 | New current address |
| seqXCnt | input | 16 | New current X count |
| seqYCnt | input | 16 | New current Y count |
| seqSetDone | input | 1 | Set done status |
| seqSetErr | input | 1 | Set error status |
| seqHalt | input | 1 | Clear run |
| startPulse | output | 1 | Launch request to the sequencer |
| stopPulse | output | 1 | Cancel request to the sequencer |
| badAccess | output | 1 | Reserved-slot write seen |
| chanRun | output | 1 | Run bit |
| doneFlag | output | 1 | Done bit |
| errFlag | output | 1 | Error bit |
| nextDescPtr | output | 32 | Next descriptor pointer |
| startAddr | output | 32 | Start address |
| cfgReg | output | 16 | Configuration |
| xCount | output | 16 | X count |
| xModify | output | 16 | X stride, signed |
| yCount | output | 16 | Y count |
| yModify | output | 16 | Y stride, signed |
| currDescPtr | output | 32 | Current descriptor pointer |
| currAddr | output | 32 | Current address |
| periphMap | output | 16 | Peripheral map |
| currXCount | output | 16 | Current X count |
| currYCount | output | 16 | Current Y count |

## Verification
Two cases can land in the same cycle. In the first, the sequencer raises done while the host writes 1 to clear it; in the second, the sequencer halts the channel while the host writes an enabling configuration word. The bench drives both inputs for one shared clock edge and then reads the status word back. It expects done still set in the first case and run still set in the second. Randomised accesses mixed with running and stopped phases then compare every readback against a bench model that applies the lock and protection rules.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;
  localparam int SLOT_W = 4;
  localparam int HADDR_W = SLOT_W + 1;
  localparam int PTR_NUM = 4;
  localparam int CNT_NUM = 6;

  localparam logic [SLOT_W-1:0] SL_NDP   = 4'd0;
  localparam logic [SLOT_W-1:0] SL_START = 4'd1;
  localparam logic [SLOT_W-1:0] SL_CFG   = 4'd2;
  localparam logic [SLOT_W-1:0] SL_XC    = 4'd4;
  localparam logic [SLOT_W-1:0] SL_XM    = 4'd5;
  localparam logic [SLOT_W-1:0] SL_YC    = 4'd6;
  localparam logic [SLOT_W-1:0] SL_YM    = 4'd7;
  localparam logic [SLOT_W-1:0] SL_CDP   = 4'd8;
  localparam logic [SLOT_W-1:0] SL_CA    = 4'd9;
  localparam logic [SLOT_W-1:0] SL_STS   = 4'd10;
  localparam logic [SLOT_W-1:0] SL_PMAP  = 4'd11;
  localparam logic [SLOT_W-1:0] SL_CXC   = 4'd12;
  localparam logic [SLOT_W-1:0] SL_CYC   = 4'd14;

  localparam int STS_DONE = 0;
  localparam int STS_ERR  = 1;
  localparam int STS_RUN  = 3;

  // pointer index: 0 next desc, 1 start, 2 current desc, 3 current addr
  // count index: 0 X count, 1 X stride, 2 Y count, 3 Y stride, 4 cur X, 5 cur Y
  typedef struct packed {
    logic [PTR_NUM-1:0] wrPtr;
    logic [CNT_NUM-1:0] wrCnt;
    logic wrCfg;
    logic wrPmap;
    logic clrSts;
    logic loHalf;
    logic hiHalf;
  } regStb_t;
endpackage

// File: rtl/dmaregs_ctrl.sv
module dmaregs_ctrl
  import dmaregs_pkg::*;
#(
  parameter int EN_BIT = 0,
  parameter int DIR_BIT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [HADDR_W-1:0] busHalfAddr,
  input  logic               busSize32,
  input  logic [31:0]        busWData,
  input  logic               runQ,
  input  logic               ctypeQ,
  output regStb_t            stb,
  output logic [31:0]        wrData,
  output logic               startPulse,
  output logic               stopPulse,
  output logic               badAccess
);
  logic wrEn;
  logic openWr;
  logic isRsv;
  logic [SLOT_W-1:0] slot;

  assign wrEn   = busSel && busWr;
  assign openWr = wrEn && !runQ;
  assign slot   = busHalfAddr[HADDR_W-1:1];
  assign wrData = busSize32 ? busWData : {busWData[15:0], busWData[15:0]};

  always_comb begin
    stb = '0;
    isRsv = 1'b0;
    stb.loHalf = busSize32 || !busHalfAddr[0];
    stb.hiHalf = busSize32 || busHalfAddr[0];
    case (slot)
      SL_NDP:   stb.wrPtr[0] = openWr;
      SL_START: stb.wrPtr[1] = openWr;
      SL_CDP:   stb.wrPtr[2] = openWr;
      SL_CA:    stb.wrPtr[3] = openWr;
      SL_XC:    stb.wrCnt[0] = openWr && stb.loHalf;
      SL_XM:    stb.wrCnt[1] = openWr && stb.loHalf;
      SL_YC:    stb.wrCnt[2] = openWr && stb.loHalf;
      SL_YM:    stb.wrCnt[3] = openWr && stb.loHalf;
      SL_CXC:   stb.wrCnt[4] = openWr && stb.loHalf;
      SL_CYC:   stb.wrCnt[5] = openWr && stb.loHalf;
      SL_CFG:   stb.wrCfg    = wrEn && stb.loHalf;
      SL_STS:   stb.clrSts   = wrEn && stb.loHalf;
      SL_PMAP:  stb.wrPmap   = openWr && stb.loHalf;
      default:  isRsv        = wrEn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      startPulse <= 1'b0;
      stopPulse  <= 1'b0;
      badAccess  <= 1'b0;
    end else begin
      startPulse <= stb.wrCfg && wrData[EN_BIT] && (!ctypeQ || wrData[DIR_BIT]);
      stopPulse  <= stb.wrCfg && !wrData[EN_BIT];
      badAccess  <= isRsv;
    end
  end

  // R7: a launch request always comes with the run bit set
  a_r7_start_runs: assert property (@(posedge clk) disable iff (rst)
    startPulse |-> runQ);
  // R6: a cancel request always comes with the run bit clear
  a_r6_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stopPulse |-> !runQ);
  // R10: a reserved write is never taken as a configuration write
  a_r10_rsv_no_pulse: assert property (@(posedge clk) disable iff (rst)
    badAccess |-> !(startPulse || stopPulse));
endmodule

// File: rtl/dmaregs_dp.sv
module dmaregs_dp
  import dmaregs_pkg::*;
#(
  parameter logic [15:0] PMAP_RESET = 16'h0040,
  parameter int CTYPE_BIT = 6,
  parameter int EN_BIT = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  regStb_t            stb,
  input  logic [31:0]        wrData,
  input  logic [HADDR_W-1:0] rdHalfAddr,
  input  logic               rdSize32,
  input  logic               seqLoad,
  input  logic [31:0]        seqDesc,
  input  logic [31:0]        seqAddr,
  input  logic [15:0]        seqXCnt,
  input  logic [15:0]        seqYCnt,
  input  logic               seqSetDone,
  input  logic               seqSetErr,
  input  logic               seqHalt,
  output logic [31:0]        rdData,
  output logic               runQ,
  output logic               doneQ,
  output logic               errQ,
  output logic               ctypeQ,
  output logic [31:0]        nextDescPtr,
  output logic [31:0]        startAddr,
  output logic [31:0]        currDescPtr,
  output logic [31:0]        currAddr,
  output logic [15:0]        cfgReg,
  output logic [15:0]        xCount,
  output logic [15:0]        xModify,
  output logic [15:0]        yCount,
  output logic [15:0]        yModify,
  output logic [15:0]        currXCount,
  output logic [15:0]        currYCount,
  output logic [15:0]        periphMap
);
  localparam logic [15:0] CT_MASK = 16'(1) << CTYPE_BIT;

  logic [31:0] ptrQ [PTR_NUM];
  logic [31:0] ptrSeq [PTR_NUM];
  logic [PTR_NUM-1:0] ptrLd;
  logic [15:0] cntQ [CNT_NUM];
  logic [15:0] cntSeq [CNT_NUM];
  logic [CNT_NUM-1:0] cntLd;
  logic [15:0] cfgQ;
  logic [15:0] pmapQ;
  logic [31:0] fullWord;

  assign ptrLd = {seqLoad, seqLoad, 2'b00};
  assign cntLd = {seqLoad, seqLoad, 4'b0000};

  always_comb begin
    ptrSeq[0] = '0;
    ptrSeq[1] = '0;
    ptrSeq[2] = seqDesc;
    ptrSeq[3] = seqAddr;
    for (int i = 0; i < 4; i++) cntSeq[i] = '0;
    cntSeq[4] = seqXCnt;
    cntSeq[5] = seqYCnt;
  end

  for (genvar g = 0; g < PTR_NUM; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) begin
        ptrQ[g] <= '0;
      end else if (ptrLd[g]) begin
        ptrQ[g] <= ptrSeq[g];
      end else if (stb.wrPtr[g]) begin
        if (stb.loHalf) ptrQ[g][15:0]  <= wrData[15:0];
        if (stb.hiHalf) ptrQ[g][31:16] <= wrData[31:16];
      end
    end
  end

  for (genvar g = 0; g < CNT_NUM; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        cntQ[g] <= '0;
      end else if (cntLd[g]) begin
        cntQ[g] <= cntSeq[g];
      end else if (stb.wrCnt[g]) begin
        cntQ[g] <= wrData[15:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ  <= '0;
      pmapQ <= PMAP_RESET;
      runQ  <= 1'b0;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      if (stb.wrCfg) cfgQ <= wrData[15:0];
      if (stb.wrPmap) pmapQ <= (wrData[15:0] & ~CT_MASK) | (pmapQ & CT_MASK);
      if (stb.wrCfg) runQ <= wrData[EN_BIT];
      else if (seqHalt) runQ <= 1'b0;
      if (seqSetDone) doneQ <= 1'b1;
      else if (stb.clrSts && wrData[STS_DONE]) doneQ <= 1'b0;
      if (seqSetErr) errQ <= 1'b1;
      else if (stb.clrSts && wrData[STS_ERR]) errQ <= 1'b0;
    end
  end

  always_comb begin
    case (rdHalfAddr[HADDR_W-1:1])
      SL_NDP:   fullWord = ptrQ[0];
      SL_START: fullWord = ptrQ[1];
      SL_CDP:   fullWord = ptrQ[2];
      SL_CA:    fullWord = ptrQ[3];
      SL_CFG:   fullWord = {16'h0, cfgQ};
      SL_XC:    fullWord = {16'h0, cntQ[0]};
      SL_XM:    fullWord = {16'h0, cntQ[1]};
      SL_YC:    fullWord = {16'h0, cntQ[2]};
      SL_YM:    fullWord = {16'h0, cntQ[3]};
      SL_CXC:   fullWord = {16'h0, cntQ[4]};
      SL_CYC:   fullWord = {16'h0, cntQ[5]};
      SL_STS:   fullWord = {28'h0, runQ, 1'b0, errQ, doneQ};
      SL_PMAP:  fullWord = {16'h0, pmapQ};
      default:  fullWord = '0;
    endcase
    if (rdSize32) rdData = fullWord;
    else rdData = {16'h0, rdHalfAddr[0] ? fullWord[31:16] : fullWord[15:0]};
  end

  assign ctypeQ      = pmapQ[CTYPE_BIT];
  assign nextDescPtr = ptrQ[0];
  assign startAddr   = ptrQ[1];
  assign currDescPtr = ptrQ[2];
  assign currAddr    = ptrQ[3];
  assign xCount      = cntQ[0];
  assign xModify     = cntQ[1];
  assign yCount      = cntQ[2];
  assign yModify     = cntQ[3];
  assign currXCount  = cntQ[4];
  assign currYCount  = cntQ[5];
  assign cfgReg      = cfgQ;
  assign periphMap   = pmapQ;

  // R3: set-up registers frozen while the channel runs
  a_r3_ndp_locked: assert property (@(posedge clk) disable iff (rst)
    runQ |=> $stable(nextDescPtr));
  a_r3_start_locked: assert property (@(posedge clk) disable iff (rst)
    runQ |=> $stable(startAddr));
  // R4: peripheral-type bit survives a map write
  a_r4_ctype_kept: assert property (@(posedge clk) disable iff (rst)
    stb.wrPmap |=> $stable(ctypeQ));
  // R5: done stays set unless cleared by a one
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (doneQ && !(stb.clrSts && wrData[STS_DONE])) |=> doneQ);
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    seqSetDone |=> doneQ);
  // R11: halt without a configuration write stops the channel
  a_r11_halt: assert property (@(posedge clk) disable iff (rst)
    (seqHalt && !stb.wrCfg) |=> !runQ);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmaregs_pkg::*;
#(
  parameter logic [15:0] PMAP_RESET = 16'h0040,
  parameter int CTYPE_BIT = 6,
  parameter int EN_BIT = 0,
  parameter int DIR_BIT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [HADDR_W-1:0] busHalfAddr,
  input  logic               busSize32,
  input  logic [31:0]        busWData,
  output logic [31:0]        busRData,
  input  logic               seqLoad,
  input  logic [31:0]        seqDesc,
  input  logic [31:0]        seqAddr,
  input  logic [15:0]        seqXCnt,
  input  logic [15:0]        seqYCnt,
  input  logic               seqSetDone,
  input  logic               seqSetErr,
  input  logic               seqHalt,
  output logic               startPulse,
  output logic               stopPulse,
  output logic               badAccess,
  output logic               chanRun,
  output logic               doneFlag,
  output logic               errFlag,
  output logic [31:0]        nextDescPtr,
  output logic [31:0]        startAddr,
  output logic [15:0]        cfgReg,
  output logic [15:0]        xCount,
  output logic [15:0]        xModify,
  output logic [15:0]        yCount,
  output logic [15:0]        yModify,
  output logic [31:0]        currDescPtr,
  output logic [31:0]        currAddr,
  output logic [15:0]        periphMap,
  output logic [15:0]        currXCount,
  output logic [15:0]        currYCount
);
  regStb_t stb;
  logic [31:0] wrData;
  logic ctypeQ;

  dmaregs_ctrl #(.EN_BIT(EN_BIT), .DIR_BIT(DIR_BIT)) ctrl_i (
    .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr),
    .busHalfAddr(busHalfAddr), .busSize32(busSize32), .busWData(busWData),
    .runQ(chanRun), .ctypeQ(ctypeQ), .stb(stb), .wrData(wrData),
    .startPulse(startPulse), .stopPulse(stopPulse), .badAccess(badAccess)
  );

  dmaregs_dp #(.PMAP_RESET(PMAP_RESET), .CTYPE_BIT(CTYPE_BIT), .EN_BIT(EN_BIT)) dp_i (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData),
    .rdHalfAddr(busHalfAddr), .rdSize32(busSize32),
    .seqLoad(seqLoad), .seqDesc(seqDesc), .seqAddr(seqAddr),
    .seqXCnt(seqXCnt), .seqYCnt(seqYCnt), .seqSetDone(seqSetDone),
    .seqSetErr(seqSetErr), .seqHalt(seqHalt), .rdData(busRData),
    .runQ(chanRun), .doneQ(doneFlag), .errQ(errFlag), .ctypeQ(ctypeQ),
    .nextDescPtr(nextDescPtr), .startAddr(startAddr),
    .currDescPtr(currDescPtr), .currAddr(currAddr), .cfgReg(cfgReg),
    .xCount(xCount), .xModify(xModify), .yCount(yCount), .yModify(yModify),
    .currXCount(currXCount), .currYCount(currYCount), .periphMap(periphMap)
  );
endmodule

// File: tb/dma_chan_regs_tb_top.sv
module dma_chan_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PMAP_DEF = 16'h0047;
  localparam int CT = 6;

  logic clk = 0, rst = 1;
  logic busSel = 0, busWr = 0, busSize32 = 0;
  logic [4:0] busHalfAddr = '0;
  logic [31:0] busWData = '0, busRData;
  logic seqLoad = 0, seqSetDone = 0, seqSetErr = 0, seqHalt = 0;
  logic [31:0] seqDesc = '0, seqAddr = '0;
  logic [15:0] seqXCnt = '0, seqYCnt = '0;
  logic startPulse, stopPulse, badAccess, chanRun, doneFlag, errFlag;
  logic [31:0] nextDescPtr, startAddr, currDescPtr, currAddr;
  logic [15:0] cfgReg, xCount, xModify, yCount, yModify, periphMap, currXCount, currYCount;

  int chkCnt = 0, failCnt = 0;
  logic [31:0] mPtr [4];
  logic [15:0] mCnt [6];
  logic [15:0] mCfg, mPmap;
  bit mRun, mDone, mErr, expStart, expStop, expBad;

  dma_chan_regs #(.PMAP_RESET(PMAP_DEF), .CTYPE_BIT(CT)) dut_i (
    .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busHalfAddr(busHalfAddr),
    .busSize32(busSize32), .busWData(busWData), .busRData(busRData),
    .seqLoad(seqLoad), .seqDesc(seqDesc), .seqAddr(seqAddr), .seqXCnt(seqXCnt),
    .seqYCnt(seqYCnt), .seqSetDone(seqSetDone), .seqSetErr(seqSetErr), .seqHalt(seqHalt),
    .startPulse(startPulse), .stopPulse(stopPulse), .badAccess(badAccess),
    .chanRun(chanRun), .doneFlag(doneFlag), .errFlag(errFlag),
    .nextDescPtr(nextDescPtr), .startAddr(startAddr), .cfgReg(cfgReg),
    .xCount(xCount), .xModify(xModify), .yCount(yCount), .yModify(yModify),
    .currDescPtr(currDescPtr), .currAddr(currAddr), .periphMap(periphMap),
    .currXCount(currXCount), .currYCount(currYCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    chkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic int ptrIdx(input int s);
    case (s) 0: return 0; 1: return 1; 8: return 2; 9: return 3; default: return -1; endcase
  endfunction
  function automatic int cntIdx(input int s);
    case (s) 4: return 0; 5: return 1; 6: return 2; 7: return 3; 12: return 4; 14: return 5;
      default: return -1; endcase
  endfunction

  function automatic logic [31:0] mFull(input int s);
    if (ptrIdx(s) >= 0) return mPtr[ptrIdx(s)];
    if (cntIdx(s) >= 0) return {16'h0, mCnt[cntIdx(s)]};
    case (s)
      2: return {16'h0, mCfg};
      10: return {28'h0, mRun, 1'b0, mErr, mDone};
      11: return {16'h0, mPmap};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mRead(input int s, input bit hi, input bit s32);
    logic [31:0] f = mFull(s);
    if (s32) return f;
    return {16'h0, hi ? f[31:16] : f[15:0]};
  endfunction

  task automatic modelWrite(input int s, input bit hi, input bit s32, input logic [31:0] d);
    bit lo = s32 || !hi;
    bit hh = s32 || hi;
    logic [31:0] wd = s32 ? d : {d[15:0], d[15:0]};
    expStart = 0; expStop = 0; expBad = 0;
    if (ptrIdx(s) >= 0) begin
      if (!mRun) begin
        if (lo) mPtr[ptrIdx(s)][15:0] = wd[15:0];
        if (hh) mPtr[ptrIdx(s)][31:16] = wd[31:16];
      end
    end else if (cntIdx(s) >= 0) begin
      if (!mRun && lo) mCnt[cntIdx(s)] = wd[15:0];
    end else if (s == 2) begin
      if (lo) begin
        mCfg = wd[15:0];
        mRun = wd[0];
        expStart = wd[0] && (!mPmap[CT] || wd[1]);
        expStop = !wd[0];
      end
    end else if (s == 10) begin
      if (lo && wd[0]) mDone = 0;
      if (lo && wd[1]) mErr = 0;
    end else if (s == 11) begin
      if (!mRun && lo) mPmap = (wd[15:0] & ~16'h0040) | (mPmap & 16'h0040);
    end else expBad = 1;
  endtask

  task automatic doWrite(input string req, input int s, input bit hi, input bit s32,
                         input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busHalfAddr = {4'(s), hi}; busSize32 = s32; busWData = d;
    modelWrite(s, hi, s32, d);
    @(negedge clk);
    busSel = 0; busWr = 0;
    chk({req, " startPulse"}, {31'h0, startPulse}, {31'h0, expStart});
    chk({req, " stopPulse"}, {31'h0, stopPulse}, {31'h0, expStop});
    chk({req, " badAccess"}, {31'h0, badAccess}, {31'h0, expBad});
  endtask

  task automatic doRead(input string req, input int s, input bit hi, input bit s32);
    @(negedge clk);
    busSel = 1; busWr = 0; busHalfAddr = {4'(s), hi}; busSize32 = s32;
    #1;
    chk(req, busRData, mRead(s, hi, s32));
    busSel = 0;
  endtask

  task automatic seqCycle(input bit ld, input logic [31:0] dsc, input logic [31:0] ad,
                          input logic [15:0] xc, input logic [15:0] yc,
                          input bit sd, input bit se, input bit hl);
    @(negedge clk);
    seqLoad = ld; seqDesc = dsc; seqAddr = ad; seqXCnt = xc; seqYCnt = yc;
    seqSetDone = sd; seqSetErr = se; seqHalt = hl;
    if (ld) begin mPtr[2] = dsc; mPtr[3] = ad; mCnt[4] = xc; mCnt[5] = yc; end
    if (sd) mDone = 1;
    if (se) mErr = 1;
    if (hl) mRun = 0;
    @(negedge clk);
    seqLoad = 0; seqSetDone = 0; seqSetErr = 0; seqHalt = 0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chkCnt++; failCnt++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 4; i++) mPtr[i] = '0;
    for (int i = 0; i < 6; i++) mCnt[i] = '0;
    mCfg = '0; mPmap = PMAP_DEF; mRun = 0; mDone = 0; mErr = 0;
    void'($urandom(32'd7531));
    repeat (3) @(negedge clk);
    rst = 0;

    // R9 reset values, R8 reserved reads as zero
    for (int s = 0; s < 16; s++) doRead("R9 reset value", s, 0, 1);
    chk("R9 run after reset", {31'h0, chanRun}, 32'h0);

    // R2 half access on a pointer slot
    doWrite("R2 hi half", 1, 1, 0, 32'h0000_BEEF);
    doWrite("R2 lo half", 1, 0, 0, 32'h0000_1234);
    doRead("R2 full word", 1, 0, 1);
    chk("R2 startAddr port", startAddr, 32'hBEEF_1234);
    doRead("R8 upper half read", 1, 1, 0);
    doWrite("R2 upper half on count slot", 4, 1, 0, 32'h0000_5555);
    doRead("R2 count unchanged", 4, 0, 1);
    doWrite("R1 X stride", 5, 0, 1, 32'hFFFF_FFFC);
    chk("R1 xModify port", {16'h0, xModify}, 32'h0000_FFFC);

    // R4 protected peripheral-type bit
    doWrite("R4 map all ones", 11, 0, 1, 32'h0000_FFFF);
    doRead("R4 map readback ones", 11, 0, 1);
    doWrite("R4 map zeros", 11, 0, 0, 32'h0);
    doRead("R4 map readback zero", 11, 0, 1);
    chk("R4 ctype held", {16'h0, periphMap}, 32'h0000_0040);

    // R10 reserved write
    doWrite("R10 reserved write", 13, 0, 1, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R10 badAccess one cycle", {31'h0, badAccess}, 32'h0);
    doRead("R10 reserved reads zero", 13, 0, 1);

    // R7 launch condition on a peripheral-type channel
    doWrite("R7 enable dir read no launch", 2, 0, 1, 32'h0000_0001);
    chk("R6 run set", {31'h0, chanRun}, 32'h1);
    doWrite("R6 disable", 2, 0, 1, 32'h0);
    doWrite("R7 enable dir write launch", 2, 0, 0, 32'h0000_0003);

    // R3 locks while running
    doWrite("R3 locked ndp", 0, 0, 1, 32'hAAAA_5555);
    doRead("R3 ndp unchanged", 0, 0, 1);
    doWrite("R3 locked count", 6, 0, 1, 32'h0000_0099);
    doRead("R3 count unchanged", 6, 0, 1);
    doWrite("R3 locked map", 11, 0, 1, 32'h0000_0001);
    doRead("R3 map unchanged", 11, 0, 1);

    // R5 W1C and status
    seqCycle(0, 0, 0, 0, 0, 1, 1, 0);
    doRead("R5 done and err set", 10, 0, 1);
    doWrite("R5 write zero no effect", 10, 0, 1, 32'h0000_0008);
    doRead("R5 still set", 10, 0, 1);
    doWrite("R5 clear done", 10, 0, 1, 32'h0000_0001);
    doRead("R5 only err left", 10, 0, 1);
    seqCycle(0, 0, 0, 0, 0, 1, 0, 0);
    // same-cycle set and clear: set wins
    @(negedge clk);
    busSel = 1; busWr = 1; busHalfAddr = {4'd10, 1'b0}; busSize32 = 1; busWData = 32'h3;
    seqSetDone = 1;
    @(negedge clk);
    busSel = 0; busWr = 0; seqSetDone = 0;
    mDone = 1; mErr = 0;
    doRead("R5 set wins over clear", 10, 0, 1);

    // R11 sequencer load and halt
    seqCycle(1, 32'h1000_0020, 32'h2000_0400, 16'd17, 16'd3, 0, 0, 0);
    doRead("R11 cur desc", 8, 0, 1);
    doRead("R11 cur addr", 9, 0, 1);
    doRead("R11 cur x", 12, 0, 1);
    doRead("R11 cur y", 14, 0, 1);
    // halt together with enabling config write: write decides
    @(negedge clk);
    busSel = 1; busWr = 1; busHalfAddr = {4'd2, 1'b0}; busSize32 = 1; busWData = 32'h3;
    seqHalt = 1;
    @(negedge clk);
    busSel = 0; busWr = 0; seqHalt = 0;
    mCfg = 16'h3; mRun = 1;
    chk("R11 config beats halt", {31'h0, chanRun}, 32'h1);
    seqCycle(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R11 halt clears run", {31'h0, chanRun}, 32'h0);
    doWrite("R6 stop pulse from disable", 2, 0, 1, 32'h0);
    doRead("R8 status half read", 10, 0, 0);

    // randomised mix
    for (int n = 0; n < 500; n++) begin
      int s = int'($urandom % 16);
      bit s32 = bit'($urandom % 2);
      bit hi = s32 ? 1'b0 : bit'($urandom % 2);
      logic [31:0] d = $urandom;
      if (s == 2 && ($urandom % 3) == 0) d[0] = 1'b0;
      doWrite("R1 R3 random write", s, hi, s32, d);
      doRead("R1 R8 random read", s, bit'($urandom % 2) & !s32, s32);
      if ((n % 50) == 0) doRead("R5 status random", 10, 0, 1);
    end
    finishRun();
  end
endmodule